// File: doc/BRIEF.md
# BAR Relocation Change Detector

This block sits beside the configuration register file of a PCI-style endpoint and watches host writes to the base address registers (BARs) and to the expansion ROM base register. It keeps its own copy of each base the host has programmed. When a full 32-bit write actually moves a region, it raises a one-cycle event that carries the old base, the new base, the region length and the region type. A downstream remap engine consumes this event to move the address window.

The register file supplies, for every BAR slot, the writable-bit mask, the size word as it is encoded in the register (the complement of size minus one), a region kind code and the current register contents. The detector ignores writes that only probe the size and writes that leave the decoded base unchanged. For a 64-bit memory BAR it stays silent on the lower-half write and reports the combined 64-bit move when the upper half is written.

Top module: `bar_move_detector`

## Requirements
- R1: Only writes with `wr_full` high (a whole 32-bit register) are considered; a write with `wr_full` low never produces an event and leaves the recorded bases unchanged.
- R2: A full write of all ones to any BAR slot is a size probe and produces no event.
- R3: A full write to a slot of kind 64-bit memory (kind code 2'b11, the lower half) produces no event.
- R4: For a slot of kind 32-bit memory (2'b01) or I/O (2'b10), a write produces an event only if (data & mask) differs from (recorded & mask); the event then carries old = recorded & mask and new = data & mask, with the upper 32 bits zero, and type code 2'b00 for memory or 2'b01 for I/O.
- R5: A slot whose lower neighbour has kind 2'b11 is an upper half, whatever its own kind. A write to it produces an event if the neighbour's masked register contents differ from the neighbour's masked recorded base, or if the masked written value differs from the slot's masked recorded base. The bases are assembled as {upper, lower}, and the type code is 2'b10.
- R6: The event length is the two's complement of the encoded size: ~size+1 over 32 bits for single slots and the ROM, and over the 64-bit concatenation {upper size, lower size} for a 64-bit pair.
- R7: A write to the ROM slot whose bits 31:11 are all ones is ignored. Any other ROM write whose masked value differs from the masked recorded ROM base gives an event of type 2'b00.
- R8: After an event, the recorded base of the written slot takes the full written value. For an upper-half event, the lower slot's recorded base also takes the lower register contents, so a repeat of the same write produces no event.
- R9: `ev_valid_o` is high for exactly the cycle after the triggering write. The payload is registered and holds until the next event, which overwrites it even when the events come back to back.
- R10: After reset all recorded bases are zero, `ev_valid_o` is low and the payload outputs are zero.
- R11: `wr_idx` values 0 to NUM_BARS-1 select a BAR slot and the value NUM_BARS selects the ROM slot. Larger values produce no event.
- R12: A slot of kind 2'b00 (unused) that is not an upper half never produces an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_full | input | 1 | The write covers all 32 bits of the register |
| wr_idx | input | IDX_W | Target slot: BAR 0..NUM_BARS-1, ROM = NUM_BARS |
| wr_data | input | REG_W | Written value |
| bar_kind_i | input | 2*NUM_BARS | Per-slot kind: 00 unused, 01 mem32, 10 I/O, 11 mem64 lower |
| bar_mask_i | input | REG_W*NUM_BARS | Per-slot writable-bit mask |
| bar_size_i | input | REG_W*NUM_BARS | Per-slot encoded size word |
| bar_reg_i | input | REG_W*NUM_BARS | Per-slot current register contents |
| rom_mask_i | input | REG_W | ROM writable-bit mask |
| rom_size_i | input | REG_W | ROM encoded size word |
| ev_valid_o | output | 1 | Event pulse |
| ev_type_o | output | 2 | 00 mem32, 01 I/O, 10 mem64 |
| ev_old_o | output | 2*REG_W | Previous base |
| ev_new_o | output | 2*REG_W | New base |
| ev_len_o | output | 2*REG_W | Region length |

## Verification
The hardest situation to reach is an upper-half write whose own value is unchanged while the lower register has moved. Only that condition should fire the event, and the old base has to come from the recorded lower base, not from the live register. The bench gets there by writing the lower slot first and mirroring the register file's update onto `bar_reg_i`, so that no event appears at that point. It then writes the upper slot with its recorded value. A sweep of every slot index, including the one past the ROM, against probe, unchanged, low-bit-only and moved values, with full and partial writes, covers the filtering rules. Recorded bases are predicted arithmetically in the bench.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
   typedef enum logic [1:0] {
      KIND_NONE  = 2'b00,
      KIND_MEM32 = 2'b01,
      KIND_IO    = 2'b10,
      KIND_MEM64 = 2'b11
   } bar_kind_e;

   typedef enum logic [1:0] {
      EVT_MEM32 = 2'b00,
      EVT_IO    = 2'b01,
      EVT_MEM64 = 2'b10
   } evt_type_e;
endpackage

// File: rtl/bmd_slot.sv
module bmd_slot
   import bmd_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter bit HAS_PREV = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic [REG_W-1:0]   data,
   input  logic [1:0]         kind,
   input  logic [REG_W-1:0]   mask,
   input  logic [REG_W-1:0]   size,
   input  logic [1:0]         prev_kind,
   input  logic [REG_W-1:0]   prev_mask,
   input  logic [REG_W-1:0]   prev_size,
   input  logic [REG_W-1:0]   prev_reg,
   input  logic [REG_W-1:0]   prev_rec,
   input  logic               next_load,
   input  logic [REG_W-1:0]   next_load_val,
   output logic [REG_W-1:0]   rec_o,
   output logic               hit_o,
   output logic [1:0]         type_o,
   output logic [2*REG_W-1:0] old_o,
   output logic [2*REG_W-1:0] new_o,
   output logic [2*REG_W-1:0] len_o,
   output logic               load_prev_o,
   output logic [REG_W-1:0]   load_prev_val_o
);
   localparam int AW = 2 * REG_W;

   logic [REG_W-1:0] rec_q;
   logic             probe, is_upper, is_single;
   logic [REG_W-1:0] m_new, m_rec, lo_new, lo_old;
   logic             hit_single, hit_upper;

   always_comb begin
      probe      = (data == {REG_W{1'b1}});
      is_upper   = HAS_PREV && (prev_kind == KIND_MEM64);
      is_single  = !is_upper && (kind == KIND_MEM32 || kind == KIND_IO);
      m_new      = data & mask;
      m_rec      = rec_q & mask;
      lo_new     = prev_reg & prev_mask;
      lo_old     = prev_rec & prev_mask;
      hit_single = sel && !probe && is_single && (m_new != m_rec);
      hit_upper  = sel && !probe && is_upper && ((lo_new != lo_old) || (m_new != m_rec));
      hit_o      = hit_single || hit_upper;
      if (is_upper) begin
         type_o = EVT_MEM64;
         old_o  = {m_rec, lo_old};
         new_o  = {m_new, lo_new};
         len_o  = ~{size, prev_size} + AW'(1);
      end else begin
         type_o = (kind == KIND_IO) ? EVT_IO : EVT_MEM32;
         old_o  = {{REG_W{1'b0}}, m_rec};
         new_o  = {{REG_W{1'b0}}, m_new};
         len_o  = {{REG_W{1'b0}}, ~size + REG_W'(1)};
      end
      load_prev_o     = hit_upper;
      load_prev_val_o = prev_reg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                rec_q <= '0;
      else if (hit_o)            rec_q <= data;
      else if (next_load)        rec_q <= next_load_val;
   end

   assign rec_o = rec_q;

   // R8
   rec_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> (rec_o == $past(data)));

   // R3
   lower64_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && kind == KIND_MEM64 && !is_upper) |-> !hit_o);
endmodule

// File: rtl/bmd_rom.sv
module bmd_rom #(
   parameter int REG_W     = 32,
   parameter int PROBE_LSB = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic [REG_W-1:0]   data,
   input  logic [REG_W-1:0]   mask,
   input  logic [REG_W-1:0]   size,
   output logic               hit_o,
   output logic [2*REG_W-1:0] old_o,
   output logic [2*REG_W-1:0] new_o,
   output logic [2*REG_W-1:0] len_o
);
   logic [REG_W-1:0] rec_q;
   logic             probe;

   always_comb begin
      probe = &data[REG_W-1:PROBE_LSB];
      hit_o = sel && !probe && ((data & mask) != (rec_q & mask));
      old_o = {{REG_W{1'b0}}, rec_q & mask};
      new_o = {{REG_W{1'b0}}, data & mask};
      len_o = {{REG_W{1'b0}}, ~size + REG_W'(1)};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rec_q <= '0;
      else if (hit_o) rec_q <= data;
   end

   // R7
   rom_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && (&data[REG_W-1:PROBE_LSB])) |=> $stable(rec_q));
endmodule

// File: rtl/bmd_evt_reg.sv
module bmd_evt_reg #(
   parameter int AW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit,
   input  logic [1:0]    typ,
   input  logic [AW-1:0] old_b,
   input  logic [AW-1:0] new_b,
   input  logic [AW-1:0] len,
   output logic          valid_o,
   output logic [1:0]    type_o,
   output logic [AW-1:0] old_o,
   output logic [AW-1:0] new_o,
   output logic [AW-1:0] len_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         type_o  <= '0;
         old_o   <= '0;
         new_o   <= '0;
         len_o   <= '0;
      end else begin
         valid_o <= hit;
         if (hit) begin
            type_o <= typ;
            old_o  <= old_b;
            new_o  <= new_b;
            len_o  <= len;
         end
      end
   end

   // R4
   ev_moved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (old_o != new_o));
endmodule

// File: rtl/bar_move_detector.sv
module bar_move_detector
   import bmd_pkg::*;
#(
   parameter int NUM_BARS      = 6,
   parameter int REG_W         = 32,
   parameter int ROM_PROBE_LSB = 11,
   parameter int IDX_W         = $clog2(NUM_BARS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      wr_full,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [REG_W-1:0]          wr_data,
   input  logic [2*NUM_BARS-1:0]     bar_kind_i,
   input  logic [REG_W*NUM_BARS-1:0] bar_mask_i,
   input  logic [REG_W*NUM_BARS-1:0] bar_size_i,
   input  logic [REG_W*NUM_BARS-1:0] bar_reg_i,
   input  logic [REG_W-1:0]          rom_mask_i,
   input  logic [REG_W-1:0]          rom_size_i,
   output logic                      ev_valid_o,
   output logic [1:0]                ev_type_o,
   output logic [2*REG_W-1:0]        ev_old_o,
   output logic [2*REG_W-1:0]        ev_new_o,
   output logic [2*REG_W-1:0]        ev_len_o
);
   localparam int AW       = 2 * REG_W;
   localparam int ROM_SLOT = NUM_BARS;

   if (NUM_BARS < 1 || NUM_BARS > 16) begin : g_bad_bars
      $error("NUM_BARS out of range");
   end
   if (ROM_PROBE_LSB < 1 || ROM_PROBE_LSB >= REG_W) begin : g_bad_lsb
      $error("ROM_PROBE_LSB out of range");
   end
   if ((1 << IDX_W) <= NUM_BARS) begin : g_bad_idx
      $error("IDX_W too narrow");
   end

   logic             wr_go;
   logic [REG_W-1:0] rec      [NUM_BARS];
   logic             hit      [NUM_BARS];
   logic [1:0]       s_type   [NUM_BARS];
   logic [AW-1:0]    s_old    [NUM_BARS];
   logic [AW-1:0]    s_new    [NUM_BARS];
   logic [AW-1:0]    s_len    [NUM_BARS];
   logic             ld_prev  [NUM_BARS];
   logic [REG_W-1:0] ld_val   [NUM_BARS];

   assign wr_go = wr_en && wr_full;

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
      logic [1:0]       p_kind;
      logic [REG_W-1:0] p_mask, p_size, p_reg, p_rec, n_val;
      logic             n_load;

      if (i == 0) begin : g_first
         assign p_kind = KIND_NONE;
         assign p_mask = '0;
         assign p_size = '0;
         assign p_reg  = '0;
         assign p_rec  = '0;
      end else begin : g_rest
         assign p_kind = bar_kind_i[2*(i-1) +: 2];
         assign p_mask = bar_mask_i[REG_W*(i-1) +: REG_W];
         assign p_size = bar_size_i[REG_W*(i-1) +: REG_W];
         assign p_reg  = bar_reg_i[REG_W*(i-1) +: REG_W];
         assign p_rec  = rec[i-1];
      end

      if (i == NUM_BARS - 1) begin : g_last
         assign n_load = 1'b0;
         assign n_val  = '0;
      end else begin : g_mid
         assign n_load = ld_prev[i+1];
         assign n_val  = ld_val[i+1];
      end

      bmd_slot #(
         .REG_W    (REG_W),
         .HAS_PREV (i > 0)
      ) u_slot (
         .clk             (clk),
         .rst_n           (rst_n),
         .sel             (wr_go && (wr_idx == IDX_W'(i))),
         .data            (wr_data),
         .kind            (bar_kind_i[2*i +: 2]),
         .mask            (bar_mask_i[REG_W*i +: REG_W]),
         .size            (bar_size_i[REG_W*i +: REG_W]),
         .prev_kind       (p_kind),
         .prev_mask       (p_mask),
         .prev_size       (p_size),
         .prev_reg        (p_reg),
         .prev_rec        (p_rec),
         .next_load       (n_load),
         .next_load_val   (n_val),
         .rec_o           (rec[i]),
         .hit_o           (hit[i]),
         .type_o          (s_type[i]),
         .old_o           (s_old[i]),
         .new_o           (s_new[i]),
         .len_o           (s_len[i]),
         .load_prev_o     (ld_prev[i]),
         .load_prev_val_o (ld_val[i])
      );
   end

   logic          rom_hit;
   logic [AW-1:0] rom_old, rom_new, rom_len;

   bmd_rom #(
      .REG_W     (REG_W),
      .PROBE_LSB (ROM_PROBE_LSB)
   ) u_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (wr_go && (wr_idx == IDX_W'(ROM_SLOT))),
      .data  (wr_data),
      .mask  (rom_mask_i),
      .size  (rom_size_i),
      .hit_o (rom_hit),
      .old_o (rom_old),
      .new_o (rom_new),
      .len_o (rom_len)
   );

   // At most one slot is selected per write, so an OR merge is sufficient.
   logic          any_hit;
   logic [1:0]    m_type;
   logic [AW-1:0] m_old, m_new, m_len;

   always_comb begin
      any_hit = rom_hit;
      m_type  = rom_hit ? EVT_MEM32 : 2'b00;
      m_old   = rom_hit ? rom_old : '0;
      m_new   = rom_hit ? rom_new : '0;
      m_len   = rom_hit ? rom_len : '0;
      for (int i = 0; i < NUM_BARS; i++) begin
         if (hit[i]) begin
            any_hit = 1'b1;
            m_type  = m_type | s_type[i];
            m_old   = m_old | s_old[i];
            m_new   = m_new | s_new[i];
            m_len   = m_len | s_len[i];
         end
      end
   end

   bmd_evt_reg #(.AW(AW)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (any_hit),
      .typ     (m_type),
      .old_b   (m_old),
      .new_b   (m_new),
      .len     (m_len),
      .valid_o (ev_valid_o),
      .type_o  (ev_type_o),
      .old_o   (ev_old_o),
      .new_o   (ev_new_o),
      .len_o   (ev_len_o)
   );

   // R1
   partial_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_full) |=> !ev_valid_o);

   // R2
   bar_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && wr_idx < IDX_W'(NUM_BARS) && wr_data == {REG_W{1'b1}}) |=> !ev_valid_o);

   // R9
   ev_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid_o |-> $past(wr_go));

   // R11
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx > IDX_W'(ROM_SLOT)) |=> !ev_valid_o);
endmodule

// File: tb/tb_bar_move_detector.sv
module tb_bar_move_detector;
   localparam int NB = 6;
   localparam int RW = 32;
   localparam int IW = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0, wr_full = 1'b0;
   logic [IW-1:0]  wr_idx = '0;
   logic [RW-1:0]  wr_data = '0;
   logic [2*NB-1:0]  bar_kind;
   logic [RW*NB-1:0] bar_mask, bar_size, bar_reg;
   logic [RW-1:0]  rom_mask, rom_size;
   logic           ev_valid;
   logic [1:0]     ev_type;
   logic [63:0]    ev_old, ev_new, ev_len;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // model state
   logic [1:0]  k [NB];
   logic [31:0] mk [NB], sz [NB], rg [NB], rc [NB];
   logic [31:0] rom_rc;

   always #10 clk = ~clk;

   bar_move_detector #(.NUM_BARS(NB), .REG_W(RW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full(wr_full),
      .wr_idx(wr_idx), .wr_data(wr_data), .bar_kind_i(bar_kind),
      .bar_mask_i(bar_mask), .bar_size_i(bar_size), .bar_reg_i(bar_reg),
      .rom_mask_i(rom_mask), .rom_size_i(rom_size), .ev_valid_o(ev_valid),
      .ev_type_o(ev_type), .ev_old_o(ev_old), .ev_new_o(ev_new), .ev_len_o(ev_len));

   always_comb begin
      for (int i = 0; i < NB; i++) begin
         bar_kind[2*i +: 2]  = k[i];
         bar_mask[RW*i +: RW] = mk[i];
         bar_size[RW*i +: RW] = sz[i];
         bar_reg[RW*i +: RW]  = rg[i];
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Expected result of a write, from the requirements; updates the model.
   task automatic predict(input int idx, input logic [31:0] d, input bit full,
                          output bit ev, output logic [1:0] ty, output logic [63:0] o,
                          output logic [63:0] n, output logic [63:0] ln, output string tag);
      ev = 0; ty = 0; o = 0; n = 0; ln = 0;
      if (!full) begin tag = "R1"; return; end
      if (idx > NB) begin tag = "R11"; return; end
      if (idx == NB) begin
         tag = "R7";
         if (d[31:11] != 21'h1FFFFF && (d & rom_mask) != (rom_rc & rom_mask)) begin
            ev = 1; ty = 2'b00; o = {32'h0, rom_rc & rom_mask};
            n = {32'h0, d & rom_mask}; ln = {32'h0, ~rom_size + 32'h1}; rom_rc = d;
         end
         return;
      end
      if (d == 32'hFFFF_FFFF) begin tag = "R2"; return; end
      if (idx > 0 && k[idx-1] == 2'b11) begin
         tag = "R5";
         if ((rg[idx-1] & mk[idx-1]) != (rc[idx-1] & mk[idx-1]) ||
             (d & mk[idx]) != (rc[idx] & mk[idx])) begin
            ev = 1; ty = 2'b10;
            o = {rc[idx] & mk[idx], rc[idx-1] & mk[idx-1]};
            n = {d & mk[idx], rg[idx-1] & mk[idx-1]};
            ln = ~{sz[idx], sz[idx-1]} + 64'h1;
            rc[idx] = d; rc[idx-1] = rg[idx-1];
         end
         return;
      end
      if (k[idx] == 2'b11) begin tag = "R3"; return; end
      if (k[idx] == 2'b00) begin tag = "R12"; return; end
      tag = "R4";
      if ((d & mk[idx]) != (rc[idx] & mk[idx])) begin
         ev = 1; ty = (k[idx] == 2'b10) ? 2'b01 : 2'b00;
         o = {32'h0, rc[idx] & mk[idx]}; n = {32'h0, d & mk[idx]};
         ln = {32'h0, ~sz[idx] + 32'h1}; rc[idx] = d;
      end
   endtask

   task automatic check_ev(input bit ev, input logic [1:0] ty, input logic [63:0] o,
                           input logic [63:0] n, input logic [63:0] ln, input string tag);
      chk(ev_valid == ev, tag, "valid", {63'h0, ev_valid}, {63'h0, ev});
      if (ev) begin
         chk(ev_type == ty, tag, "type", {62'h0, ev_type}, {62'h0, ty});
         chk(ev_old == o, tag, "old", ev_old, o);
         chk(ev_new == n, tag, "new", ev_new, n);
         chk(ev_len == ln, "R6", "len", ev_len, ln);
      end
   endtask

   // mirror of the register file's update of the written register
   task automatic regfile_update(input int idx, input logic [31:0] d, input bit full);
      if (full && idx < NB)
         rg[idx] = (d == 32'hFFFF_FFFF) ? (d & mk[idx] & sz[idx]) : (d & mk[idx]);
   endtask

   task automatic do_write(input int idx, input logic [31:0] d, input bit full,
                           input string tag_over);
      bit ev; logic [1:0] ty; logic [63:0] o, n, ln; string tag;
      @(negedge clk);
      wr_en = 1; wr_full = full; wr_idx = IW'(idx); wr_data = d;
      predict(idx, d, full, ev, ty, o, n, ln, tag);
      if (tag_over != "") tag = tag_over;
      @(negedge clk);
      wr_en = 0; wr_full = 0;
      regfile_update(idx, d, full);
      check_ev(ev, ty, o, n, ln, tag);
      @(negedge clk);
      chk(ev_valid == 1'b0, "R9", "pulse end", {63'h0, ev_valid}, 64'h0);
   endtask

   initial begin
      k[0] = 2'b01; mk[0] = 32'hFFFF_FFF0; sz[0] = 32'hFFFF_F000;
      k[1] = 2'b10; mk[1] = 32'hFFFF_FFFC; sz[1] = 32'hFFFF_FF00;
      k[2] = 2'b11; mk[2] = 32'hFFFF_FFF0; sz[2] = 32'hFFFF_0000;
      k[3] = 2'b00; mk[3] = 32'hFFFF_FFFF; sz[3] = 32'hFFFF_FFFF;
      k[4] = 2'b00; mk[4] = 32'hFFFF_FFF0; sz[4] = 32'hFFFF_F000;
      k[5] = 2'b01; mk[5] = 32'hFFFF_FFF0; sz[5] = 32'hFFFF_FFF0;
      rom_mask = 32'hFFFF_F800; rom_size = 32'hFFFF_0000;
      for (int i = 0; i < NB; i++) begin rg[i] = '0; rc[i] = '0; end
      rom_rc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10: reset state
      chk(ev_valid == 1'b0, "R10", "valid", {63'h0, ev_valid}, 64'h0);
      chk(ev_old == 64'h0 && ev_new == 64'h0 && ev_len == 64'h0, "R10", "payload",
          ev_old | ev_new | ev_len, 64'h0);
      // R10: zero recorded base means writing zero is not a move
      do_write(0, 32'h0000_0000, 1'b1, "R10");
      do_write(NB, 32'h0000_0000, 1'b1, "R10");

      // sweep: every index, every pattern, partial then full
      for (int idx = 0; idx <= NB + 1; idx++) begin
         for (int p = 0; p < 6; p++) begin
            for (int f = 0; f < 2; f++) begin
               logic [31:0] base, d;
               base = (idx < NB) ? rc[idx] : rom_rc;
               case (p)
                  0: d = 32'hFFFF_FFFF;
                  1: d = 32'h1234_5670 + (32'(idx) << 20);
                  2: d = base;
                  3: d = base ^ 32'h0000_0003;
                  4: d = 32'hFFFF_F8A5;
                  default: d = 32'h8000_0000 + (32'(idx) << 16);
               endcase
               do_write(idx, d, f[0], "");
            end
         end
      end

      // R5: lower moved, upper unchanged -> event on upper write only
      do_write(2, 32'hA000_0000, 1'b1, "R3");
      do_write(3, rc[3], 1'b1, "R5");
      // R8: same upper write again, both halves now recorded
      do_write(3, rc[3], 1'b1, "R8");
      // R5: upper moved only
      do_write(3, 32'h0000_0007, 1'b1, "R5");
      // R8: repeat single-slot move is quiet
      do_write(5, 32'h4444_4440, 1'b1, "R4");
      do_write(5, 32'h4444_4440, 1'b1, "R8");

      // R9: back-to-back events, second overwrites first
      begin
         bit e1, e2; logic [1:0] t1, t2; logic [63:0] o1, n1, l1, o2, n2, l2; string g;
         @(negedge clk);
         wr_en = 1; wr_full = 1; wr_idx = 0; wr_data = 32'h5555_0000;
         predict(0, 32'h5555_0000, 1'b1, e1, t1, o1, n1, l1, g);
         @(negedge clk);
         regfile_update(0, 32'h5555_0000, 1'b1);
         check_ev(e1, t1, o1, n1, l1, "R9");
         wr_idx = 1; wr_data = 32'h0000_6664;
         predict(1, 32'h0000_6664, 1'b1, e2, t2, o2, n2, l2, g);
         @(negedge clk);
         wr_en = 0; wr_full = 0;
         regfile_update(1, 32'h0000_6664, 1'b1);
         check_ev(e2, t2, o2, n2, l2, "R9");
         @(negedge clk);
         chk(ev_valid == 1'b0, "R9", "pulse end", {63'h0, ev_valid}, 64'h0);
         chk(ev_new == n2, "R9", "payload held", ev_new, n2);
      end

      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule